// File: doc/BRIEF.md
# Vectored Edge/Level Interrupt Controller

This block collects up to 64 interrupt inputs and steers each of them onto one of several parent interrupt lines. Every source is either edge or level sensitive, has its own mask bit, and carries a pending bit and an in-service bit. An 8-bit vector entry per source chooses which parent line the source drives. Software reaches the block through a plain 32-bit register bus. The 64-bit control vectors are split into low and high words, and the vector and route tables are reached one byte at a time.

The inputs are sampled on every clock. A rising input, or a mask bit that opens, starts an assertion evaluation. A falling input, a mask bit that closes, or an accepted clear starts a deassertion evaluation. Each evaluation acts on at most one source, the lowest-numbered eligible one, and moves a registered parent line. Sources that are pending but were not picked stay pending without being taken into service. The route table and the polarity and enable words are storage only. The auto-control words read zero and ignore writes.

Top module: `vec_intc`

## Requirements
- R1: After reset, all mask bits are 1. The edge, enable, polarity, pending, in-service and last-level vectors are 0. Every vector entry is 0, every route entry is 1, and all parent lines are low.
- R2: A level-mode source copies its input into its pending bit on every clock. A parent line changes only in the clock after an input change or a bus write.
- R3: An edge-mode source sets its pending bit only when its input goes from low to high. A falling input leaves pending set, so its parent line stays high.
- R4: An assertion evaluation looks at the sources that rose or were unmasked in this clock and are pending and unmasked. It puts the lowest-numbered of them in service and raises the parent line `vector[source]`. At most one parent line rises per clock. A vector value of N_OUT or more drives no line.
- R5: A deassertion evaluation looks at the sources that fell, were masked, or were cleared in this clock and are in service but no longer pending. It takes the lowest-numbered of them out of service and lowers its parent line. At most one parent line falls per clock.
- R6: A mask write (low word 0x008, high word 0x00C; 1 means masked) runs an assertion evaluation on the bits that open and a deassertion evaluation on the bits that close. Masking a source that is still pending leaves its parent line high.
- R7: A write to the clear word (0x020 low, 0x024 high) acts only if at least one written bit is edge mode. It then clears pending on the written edge bits, runs a deassertion evaluation, and clears in-service on all written bits. If no written bit is edge mode, the write does nothing.
- R8: The 64-bit words are mask (0x008/0x00C), edge (0x010/0x014, 1 means edge), enable (0x018/0x01C), status (0x028/0x02C) and polarity (0x030/0x034). A write to one half leaves the other half unchanged. Read data appears on `bus_rdata` one clock after the read request.
- R9: Word 0x000 reads the IDENT parameter. Word 0x004 reads N_SRC-1 in bits 31:16 and VERSION in bits 15:0.
- R10: A status read returns in-service AND NOT mask. A status write overwrites the addressed half of the in-service vector without moving any parent line.
- R11: The vector table sits at 0x100+i and the route table at 0x200+i, data in bits 7:0. An index of 64 or more reads 0 and ignores writes. The auto-control words 0x038 to 0x044 read 0.
- R12: If a deassertion and an assertion in the same clock target the same parent line, the line ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Interrupt source inputs |
| bus_sel | input | 1 | Bus access request |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after the read |
| parent_irq | output | N_OUT | Registered parent interrupt lines |

## Verification
An assertion evaluation and a deassertion evaluation can resolve in the same clock. When both land on one parent line, the update order decides the line's level. The bench provokes this by sending two level sources to the same vector and, on one falling clock edge, dropping the source that is in service while raising the other. It then expects the shared line to stay high and the status to name only the new source. A second overlap is a mask write that closes a bit while its input is still high. The bench judges it by the parent line staying high while the status word reads zero.

// File: rtl/vec_intc.sv
module vec_intc #(
  parameter int N_SRC = 64,
  parameter int N_OUT = 16,
  parameter logic [15:0] VERSION = 16'h0001,
  parameter logic [31:0] IDENT = 32'h1C0A_0001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [N_OUT-1:0] parent_irq
);
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1;

  logic [63:0] mask_q, edge_q, en_q, pol_q, pend_q, isr_q, last_q;
  logic [7:0]  vec_tab [64];
  logic [7:0]  rte_tab [64];

  function automatic logic [63:0] half_upd(input logic [63:0] old, input logic [31:0] d, input logic hi);
    return hi ? {d, old[31:0]} : {old[63:32], d};
  endfunction

  function automatic logic [5:0] lowest(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--)
      if (v[i]) r = 6'(i);
    return r;
  endfunction

  wire [63:0] lvl   = 64'(irq_in);
  wire        wr    = bus_sel & bus_we;
  wire        hi    = bus_addr[2];
  wire [8:0]  pair  = bus_addr[11:3];
  wire [7:0]  tidx  = bus_addr[7:0];
  wire        t_in  = (tidx < 8'd64);
  wire [63:0] wd_sh = hi ? {bus_wdata, 32'h0} : {32'h0, bus_wdata};

  wire wr_mask = wr && pair == 9'd1;
  wire wr_edge = wr && pair == 9'd2;
  wire wr_en   = wr && pair == 9'd3;
  wire wr_clr  = wr && pair == 9'd4;
  wire wr_stat = wr && pair == 9'd5;
  wire wr_pol  = wr && pair == 9'd6;

  wire [63:0] mask_n = wr_mask ? half_upd(mask_q, bus_wdata, hi) : mask_q;
  wire [63:0] rise   = lvl & ~last_q;
  wire [63:0] fall   = ~lvl & last_q;
  wire [63:0] clr    = (wr_clr && |(edge_q & wd_sh)) ? wd_sh : 64'h0;
  wire [63:0] pend_n = (edge_q & ((pend_q & ~clr) | rise)) | (~edge_q & lvl);

  wire [63:0] a_cand = (rise | (mask_q & ~mask_n)) & pend_n & ~mask_n;
  wire [63:0] d_cand = (fall | (~mask_q & mask_n) | clr) & isr_q & ~pend_n;
  wire        a_any  = |a_cand;
  wire        d_any  = |d_cand;
  wire [5:0]  a_idx  = lowest(a_cand);
  wire [5:0]  d_idx  = lowest(d_cand);
  wire [7:0]  a_vec  = vec_tab[a_idx];
  wire [7:0]  d_vec  = vec_tab[d_idx];

  wire [63:0] isr_b = wr_stat ? half_upd(isr_q, bus_wdata, hi) : isr_q;
  wire [63:0] isr_n = ((isr_b & ~(d_any ? (64'h1 << d_idx) : 64'h0))
                      | (a_any ? (64'h1 << a_idx) : 64'h0)) & ~clr;

  logic [N_OUT-1:0] par_n;
  always_comb begin
    par_n = parent_irq;
    if (d_any && 32'(d_vec) < N_OUT) par_n[OW'(d_vec)] = 1'b0;
    if (a_any && 32'(a_vec) < N_OUT) par_n[OW'(a_vec)] = 1'b1;
  end

  function automatic logic [31:0] pick(input logic [63:0] v, input logic h);
    return h ? v[63:32] : v[31:0];
  endfunction

  logic [31:0] rd_v;
  always_comb begin
    rd_v = '0;
    case (bus_addr[11:8])
      4'h0: case (pair)
        9'd0:    rd_v = hi ? {16'(N_SRC - 1), VERSION} : IDENT;
        9'd1:    rd_v = pick(mask_q, hi);
        9'd2:    rd_v = pick(edge_q, hi);
        9'd3:    rd_v = pick(en_q, hi);
        9'd5:    rd_v = pick(isr_q & ~mask_q, hi);
        9'd6:    rd_v = pick(pol_q, hi);
        default: rd_v = '0;
      endcase
      4'h1: rd_v = t_in ? {24'h0, vec_tab[tidx[5:0]]} : 32'h0;
      4'h2: rd_v = t_in ? {24'h0, rte_tab[tidx[5:0]]} : 32'h0;
      default: rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      {edge_q, en_q, pol_q, pend_q, isr_q, last_q} <= '0;
      parent_irq <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < 64; i++) begin
        vec_tab[i] <= 8'h00;
        rte_tab[i] <= 8'h01;
      end
    end else begin
      mask_q <= mask_n;
      pend_q <= pend_n;
      isr_q  <= isr_n;
      last_q <= lvl;
      parent_irq <= par_n;
      if (wr_edge) edge_q <= half_upd(edge_q, bus_wdata, hi);
      if (wr_en)   en_q   <= half_upd(en_q, bus_wdata, hi);
      if (wr_pol)  pol_q  <= half_upd(pol_q, bus_wdata, hi);
      if (wr && bus_addr[11:8] == 4'h1 && t_in) vec_tab[tidx[5:0]] <= bus_wdata[7:0];
      if (wr && bus_addr[11:8] == 4'h2 && t_in) rte_tab[tidx[5:0]] <= bus_wdata[7:0];
      if (bus_sel && !bus_we) bus_rdata <= rd_v;
    end
  end
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int N_SRC = 64,
  parameter int N_OUT = 16,
  parameter logic [15:0] VERSION = 16'h0001
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] irq_in,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [11:0]      bus_addr,
  input logic [31:0]      bus_rdata,
  input logic [N_OUT-1:0] parent_irq
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_one_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 0) |-> ($countones(parent_irq & ~$past(parent_irq)) <= 1));

  p_one_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 0) |-> ($countones(~parent_irq & $past(parent_irq)) <= 1));

  p_needs_stim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && parent_irq != $past(parent_irq)) |->
      ($past(irq_in) != $past(irq_in, 2) || $past(bus_sel && bus_we)));

  p_table_oob_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 0 && $past(bus_sel && !bus_we && (bus_addr[11:8] == 4'h1 || bus_addr[11:8] == 4'h2)
      && bus_addr[7:6] != 2'b00)) |-> (bus_rdata == 32'h0));

  p_id_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 0 && $past(bus_sel && !bus_we && bus_addr == 12'h004)) |->
      (bus_rdata == {16'(N_SRC - 1), VERSION}));
endmodule

bind vec_intc vec_intc_chk #(.N_SRC(N_SRC), .N_OUT(N_OUT), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .parent_irq(parent_irq));

// File: tb/vec_intc_test.sv
module vec_intc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] parent_irq;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  vec_intc uut (.clk(clk), .rst_n(rst_n), .irq_in(irq), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .parent_irq(parent_irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; irq = '0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_sel = 1'b0; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 parent", 32'(parent_irq), 0);
    rd(12'h008, v); chk("R1 mask lo", v, 32'hFFFF_FFFF);
    rd(12'h00C, v); chk("R1 mask hi", v, 32'hFFFF_FFFF);
    rd(12'h010, v); chk("R1 edge lo", v, 0);
    rd(12'h105, v); chk("R1 vector", v, 0);
    rd(12'h205, v); chk("R1 route", v, 1);
    rd(12'h004, v); chk("R9 id hi", v, 32'h003F_0001);
    rd(12'h000, v); chk("R9 id lo", v, 32'h1C0A_0001);
  endtask

  task automatic t_level();
    logic [31:0] v;
    do_reset();
    wr(12'h103, 2); wr(12'h008, ~32'h8);
    chk("R2 idle", 32'(parent_irq), 0);
    @(negedge clk); irq[3] = 1'b1; @(negedge clk);
    chk("R4 level raise", 32'(parent_irq), 32'h4);
    rd(12'h028, v); chk("R10 status", v, 32'h8);
    wr(12'h020, 32'h8);
    chk("R7 clear on level ignored", 32'(parent_irq), 32'h4);
    rd(12'h028, v); chk("R7 status kept", v, 32'h8);
    wr(12'h008, 32'hFFFF_FFFF);
    chk("R6 mask pending keeps line", 32'(parent_irq), 32'h4);
    rd(12'h028, v); chk("R10 masked status", v, 0);
    @(negedge clk); irq[3] = 1'b0; @(negedge clk);
    chk("R5 level fall", 32'(parent_irq), 0);
    wr(12'h106, 1);
    @(negedge clk); irq[6] = 1'b1; @(negedge clk);
    chk("R6 masked no raise", 32'(parent_irq), 0);
    wr(12'h008, ~32'h40);
    chk("R6 unmask raises", 32'(parent_irq), 32'h2);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    wr(12'h010, 32'h10); wr(12'h104, 5); wr(12'h008, ~32'h10);
    @(negedge clk); irq[4] = 1'b1; @(negedge clk);
    chk("R3 edge rise", 32'(parent_irq), 32'h20);
    @(negedge clk); irq[4] = 1'b0; @(negedge clk); @(negedge clk);
    chk("R3 edge fall holds", 32'(parent_irq), 32'h20);
    rd(12'h028, v); chk("R3 status", v, 32'h10);
    wr(12'h020, 32'h10);
    chk("R7 clear lowers", 32'(parent_irq), 0);
    rd(12'h028, v); chk("R7 status cleared", v, 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    do_reset();
    wr(12'h108, 3); wr(12'h109, 4); wr(12'h008, ~32'h300);
    @(negedge clk); irq[9:8] = 2'b11; @(negedge clk);
    chk("R4 lowest only", 32'(parent_irq), 32'h8);
    rd(12'h028, v); chk("R4 status lowest", v, 32'h100);
  endtask

  task automatic t_halves();
    logic [31:0] v;
    do_reset();
    wr(12'h010, 32'h1234_5678); wr(12'h014, 32'hA5);
    rd(12'h010, v); chk("R8 edge lo kept", v, 32'h1234_5678);
    rd(12'h014, v); chk("R8 edge hi", v, 32'hA5);
    wr(12'h034, 32'h77); rd(12'h030, v); chk("R8 pol lo", v, 0);
    rd(12'h034, v); chk("R8 pol hi", v, 32'h77);
    wr(12'h00C, 32'h0); rd(12'h008, v); chk("R8 mask lo kept", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_status_wr();
    logic [31:0] v;
    do_reset();
    wr(12'h028, 32'h1);
    chk("R10 status write no line", 32'(parent_irq), 0);
    rd(12'h028, v); chk("R10 masked read", v, 0);
    wr(12'h008, 32'hFFFF_FFFE);
    rd(12'h028, v); chk("R10 status visible", v, 32'h1);
    chk("R6 unmask no pending", 32'(parent_irq), 0);
  endtask

  task automatic t_tables();
    logic [31:0] v;
    do_reset();
    wr(12'h146, 32'h55); rd(12'h146, v); chk("R11 vec oob", v, 0);
    wr(12'h205, 32'h9);  rd(12'h205, v); chk("R11 route rw", v, 32'h9);
    wr(12'h13F, 32'hAB); rd(12'h13F, v); chk("R11 vec last", v, 32'hAB);
    wr(12'h040, 32'hFFFF); rd(12'h040, v); chk("R11 auto ctrl", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    wr(12'h10A, 7); wr(12'h10B, 7); wr(12'h008, ~32'hC00);
    @(negedge clk); irq[10] = 1'b1; @(negedge clk);
    chk("R12 first", 32'(parent_irq), 32'h80);
    @(negedge clk); irq[10] = 1'b0; irq[11] = 1'b1; @(negedge clk);
    chk("R12 shared line high", 32'(parent_irq), 32'h80);
    rd(12'h028, v); chk("R12 status", v, 32'h800);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog got=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_priority();
    t_halves();
    t_status_wr();
    t_tables();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule